// File: doc/BRIEF.md
# I2C Master Register Front-End

This block is the software-facing side of an I2C master. A simple 32-bit bus with byte offsets reaches a set of registers: configuration with soft reset and enable, a bus-speed select, FIFO control, a command register, interrupt enable and interrupt status, and two data windows. Behind the data windows sit a 64-entry transmit FIFO, which holds a byte plus a last-byte tag, and a 64-entry receive FIFO. The bit-level bus engine sits outside this block. It takes a one-cycle start pulse with the protocol code and read count, drains the transmit FIFO, fills the receive FIFO, and reports the end of the transaction with a done pulse and a three-bit result code.

The command register has two roles. Software writes it to launch a transaction, then polls the same register, which shows busy and then the coded result. When busy drops, a sticky interrupt flag is set. The flag drives the interrupt line through its enable bit, and software clears it by writing a one to it. Bus reads have one cycle of latency: `rdata` is registered and is valid in the cycle after `rd_en`.

Top module: `i2cf_regs`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and both FIFOs are empty.
- R2: Config (0x00) keeps bit 31 (soft reset) and bit 30 (enable), and timing (0x04) keeps bit 31 (fast mode). The stored bits read back as written, all other bits read zero, and `eng_enable` and `eng_fast` follow them.
- R3: A write to command (0x30) with bit 31 set, made while enabled and idle, has three effects. It sets busy (bit 31 reads 1). It pulses `eng_start` for exactly one cycle. It latches the protocol code from bits 12:9 and the read count from bits 7:0. If the block is disabled or already busy, the write changes nothing.
- R4: An `eng_done` pulse while busy clears bit 31 and places `eng_status` into command bits 27:25. Starting a new transaction clears those bits.
- R5: When busy falls, interrupt status (0x3C) bit 28 is set. `irq` is high exactly when that bit and interrupt enable (0x38) bit 28 are both set.
- R6: Writing 1 to status bit 28 clears it. Writing 0 leaves it unchanged.
- R7: A write to the transmit window (0x40) pushes data bits 7:0 and the last-byte tag from bit 31. The engine sees the entries in first-in, first-out order. A write made while 64 entries are held is dropped.
- R8: A read of the receive window (0x44) pops the oldest byte into bits 7:0. A read when the FIFO is empty returns zero and leaves it empty. FIFO control bits 22:16 read back the receive fill level. Engine pushes made while the receive FIFO is full are dropped.
- R9: Writing FIFO control (0x0C) with bit 31 set empties the receive FIFO. Bit 30 empties the transmit FIFO.
- R10: While config bit 31 is set, both FIFOs, busy, the result code and interrupt status are held cleared, and transmit writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Completion interrupt |
| eng_start | output | 1 | One-cycle transaction start pulse |
| eng_protocol | output | 4 | Latched protocol code |
| eng_rd_count | output | 8 | Latched read byte count |
| eng_enable | output | 1 | Controller enable |
| eng_fast | output | 1 | Fast-mode select |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_tx_data | output | 8 | Transmit FIFO head byte |
| eng_tx_last | output | 1 | Last-byte tag of the head entry |
| eng_tx_pop | input | 1 | Engine consumes the head entry |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_done | input | 1 | Transaction finished pulse |
| eng_status | input | 3 | Result code taken on eng_done |

## Verification
The bench fills both FIFOs past 64 entries. A design without full protection would wrap around and either corrupt the oldest entries or lose the fill count. It reads an empty receive window, where an underflow would return stale data and push the level negative. It issues a second start while busy, which a design that re-arms on every write would pass through as a second `eng_start` pulse with a changed protocol. It also checks that writing zero to the status register leaves the flag set, that a masked flag keeps `irq` low, and that a soft reset held during an active transaction clears busy, the flag and both FIFOs together.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int BYTE_W   = 8;
  localparam int FIFO_DEP = 64;
  localparam int PROT_W   = 4;
  localparam int STAT_W   = 3;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_TIM  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_FIFO = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_IE   = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_IS   = 8'h3C;
  localparam logic [ADDR_W-1:0] OFF_TX   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_RX   = 8'h44;

  localparam int B_SRST   = 31;
  localparam int B_EN     = 30;
  localparam int B_FAST   = 31;
  localparam int B_RXFL   = 31;
  localparam int B_TXFL   = 30;
  localparam int B_BUSY   = 31;
  localparam int B_DONEIF = 28;
  localparam int B_LAST   = 31;
  localparam int B_STAT   = 25;
  localparam int B_PROT   = 9;
  localparam int B_LVL    = 16;
endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [W-1:0]      din,
  input  logic              pop,
  output logic [W-1:0]      dout,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         do_push, do_pop;

  assign level   = wptr - rptr;
  assign empty   = (wptr == rptr);
  assign full    = (level == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && !push && !flush) |=> empty);
endmodule

// File: rtl/i2cf_cmd.sv
module i2cf_cmd #(
  parameter int CNT_W  = 8,
  parameter int PROT_W = 4,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic              enable,
  input  logic              start_req,
  input  logic [PROT_W-1:0] wprot,
  input  logic [CNT_W-1:0]  wcnt,
  input  logic              eng_done,
  input  logic [STAT_W-1:0] eng_status,
  input  logic              flag_clr,
  output logic              busy,
  output logic              start_pulse,
  output logic [STAT_W-1:0] status,
  output logic [PROT_W-1:0] prot,
  output logic [CNT_W-1:0]  cnt,
  output logic              flag
);
  logic finish;
  assign finish = busy && eng_done;

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      busy        <= 1'b0;
      start_pulse <= 1'b0;
      status      <= '0;
      prot        <= '0;
      cnt         <= '0;
      flag        <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (!busy && start_req && enable) begin
        busy        <= 1'b1;
        start_pulse <= 1'b1;
        prot        <= wprot;
        cnt         <= wcnt;
        status      <= '0;
      end else if (finish) begin
        busy   <= 1'b0;
        status <= eng_status;
      end
      if (finish)        flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  assert_flag_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(srst)) |-> flag);

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done && !srst) |=> busy);

  assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);
endmodule

// File: rtl/i2cf_regs.sv
module i2cf_regs
  import i2cf_pkg::*;
#(
  parameter int DEPTH = FIFO_DEP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq,
  output logic              eng_start,
  output logic [PROT_W-1:0] eng_protocol,
  output logic [BYTE_W-1:0] eng_rd_count,
  output logic              eng_enable,
  output logic              eng_fast,
  output logic              eng_tx_valid,
  output logic [BYTE_W-1:0] eng_tx_data,
  output logic              eng_tx_last,
  input  logic              eng_tx_pop,
  input  logic              eng_rx_push,
  input  logic [BYTE_W-1:0] eng_rx_data,
  input  logic              eng_done,
  input  logic [STAT_W-1:0] eng_status
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic srst_q, en_q, fast_q, ie_q;
  logic w_cfg, w_tim, w_fifo, w_cmd, w_ie, w_is, w_tx, r_rx;
  logic busy, flag;
  logic [STAT_W-1:0] status;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [LW-1:0] tx_level, rx_level;
  logic [BYTE_W:0] tx_dout;
  logic [BYTE_W-1:0] rx_dout;
  logic [REG_W-1:0] rd_mux;

  assign w_cfg  = wr_en && addr == OFF_CFG;
  assign w_tim  = wr_en && addr == OFF_TIM;
  assign w_fifo = wr_en && addr == OFF_FIFO;
  assign w_cmd  = wr_en && addr == OFF_CMD;
  assign w_ie   = wr_en && addr == OFF_IE;
  assign w_is   = wr_en && addr == OFF_IS;
  assign w_tx   = wr_en && addr == OFF_TX && !srst_q;
  assign r_rx   = rd_en && addr == OFF_RX;

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_q <= 1'b0;
      en_q   <= 1'b0;
      fast_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (w_cfg) begin
        srst_q <= wdata[B_SRST];
        en_q   <= wdata[B_EN];
      end
      if (w_tim) fast_q <= wdata[B_FAST];
      if (w_ie)  ie_q   <= wdata[B_DONEIF];
    end
  end

  i2cf_cmd #(.CNT_W(BYTE_W), .PROT_W(PROT_W), .STAT_W(STAT_W)) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .srst       (srst_q),
    .enable     (en_q),
    .start_req  (w_cmd && wdata[B_BUSY]),
    .wprot      (wdata[B_PROT +: PROT_W]),
    .wcnt       (wdata[BYTE_W-1:0]),
    .eng_done   (eng_done),
    .eng_status (eng_status),
    .flag_clr   (w_is && wdata[B_DONEIF]),
    .busy       (busy),
    .start_pulse(eng_start),
    .status     (status),
    .prot       (eng_protocol),
    .cnt        (eng_rd_count),
    .flag       (flag)
  );

  i2cf_fifo #(.W(BYTE_W+1), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .flush (srst_q || (w_fifo && wdata[B_TXFL])),
    .push  (w_tx),
    .din   ({wdata[B_LAST], wdata[BYTE_W-1:0]}),
    .pop   (eng_tx_pop),
    .dout  (tx_dout),
    .empty (tx_empty),
    .full  (tx_full),
    .level (tx_level)
  );

  i2cf_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .flush (srst_q || (w_fifo && wdata[B_RXFL])),
    .push  (eng_rx_push),
    .din   (eng_rx_data),
    .pop   (r_rx),
    .dout  (rx_dout),
    .empty (rx_empty),
    .full  (rx_full),
    .level (rx_level)
  );

  assign eng_tx_valid = !tx_empty;
  assign eng_tx_data  = tx_dout[BYTE_W-1:0];
  assign eng_tx_last  = tx_dout[BYTE_W];
  assign eng_enable   = en_q;
  assign eng_fast     = fast_q;
  assign irq          = flag && ie_q;

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFF_CFG:  begin rd_mux[B_SRST] = srst_q; rd_mux[B_EN] = en_q; end
      OFF_TIM:  rd_mux[B_FAST] = fast_q;
      OFF_FIFO: rd_mux[B_LVL +: LW] = rx_level;
      OFF_CMD:  begin
        rd_mux[B_BUSY]            = busy;
        rd_mux[B_STAT +: STAT_W]  = status;
        rd_mux[B_PROT +: PROT_W]  = eng_protocol;
        rd_mux[BYTE_W-1:0]        = eng_rd_count;
      end
      OFF_IE:   rd_mux[B_DONEIF] = ie_q;
      OFF_IS:   rd_mux[B_DONEIF] = flag;
      OFF_RX:   if (!rx_empty) rd_mux[BYTE_W-1:0] = rx_dout;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  logic unused_bits;
  assign unused_bits = ^{tx_full, rx_full, tx_level};

  assert_srst_clear_R10: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (!busy && !flag && rx_empty && tx_empty));
endmodule

// File: tb/i2cf_regs_tb.sv
module i2cf_regs_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic irq, eng_start, eng_enable, eng_fast, eng_tx_valid, eng_tx_last;
  logic [3:0] eng_protocol;
  logic [7:0] eng_rd_count, eng_tx_data;
  logic eng_tx_pop = 0, eng_rx_push = 0, eng_done = 0;
  logic [7:0] eng_rx_data = 0;
  logic [2:0] eng_status = 0;

  int n_checks = 0, n_fail = 0, n_starts = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 0;

  always #(CLK_P/2) clk = ~clk;

  i2cf_regs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .eng_start(eng_start),
    .eng_protocol(eng_protocol), .eng_rd_count(eng_rd_count),
    .eng_enable(eng_enable), .eng_fast(eng_fast),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
    .eng_tx_last(eng_tx_last), .eng_tx_pop(eng_tx_pop),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_done(eng_done), .eng_status(eng_status)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when read data is due
  always @(posedge clk) begin
    rd_d <= rd_en;
    if (eng_start) n_starts <= n_starts + 1;
  end
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) check(rdata, 32'hDEAD, "scoreboard-empty");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic br(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1; addr = a; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); eng_rx_push = 1; eng_rx_data = d;
    @(negedge clk); eng_rx_push = 0;
  endtask

  task automatic tx_pop(input logic [7:0] ed, input logic el, input string tag);
    @(negedge clk);
    check({31'b0, eng_tx_valid}, 32'd1, tag);
    check({24'b0, eng_tx_data}, {24'b0, ed}, tag);
    check({31'b0, eng_tx_last}, {31'b0, el}, tag);
    eng_tx_pop = 1;
    @(negedge clk); eng_tx_pop = 0;
  endtask

  task automatic done(input logic [2:0] st);
    @(negedge clk); eng_done = 1; eng_status = st;
    @(negedge clk); eng_done = 0;
  endtask

  initial begin
    #(CLK_P*100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    br(8'h00, 0, "R1 cfg"); br(8'h30, 0, "R1 cmd");
    br(8'h3C, 0, "R1 is");  br(8'h0C, 0, "R1 fifo");
    check({31'b0, irq}, 0, "R1 irq");
    check({31'b0, eng_tx_valid}, 0, "R1 txq");
    // R3 start ignored while disabled
    bw(8'h30, 32'h8000_0000);
    br(8'h30, 0, "R3 start while disabled");
    // R2 config and timing
    bw(8'h00, 32'h4000_00FF); bw(8'h04, 32'h8000_0001);
    br(8'h00, 32'h4000_0000, "R2 cfg readback");
    br(8'h04, 32'h8000_0000, "R2 tim readback");
    check({30'b0, eng_enable, eng_fast}, 32'd3, "R2 engine controls");
    // R7 transmit order and tag
    bw(8'h40, 32'h0000_00AB); bw(8'h40, 32'h8000_00CD);
    tx_pop(8'hAB, 0, "R7 first"); tx_pop(8'hCD, 1, "R7 tagged last");
    @(negedge clk); check({31'b0, eng_tx_valid}, 0, "R7 drained");
    // R3 start
    bw(8'h38, 32'h1000_0000);
    bw(8'h30, 32'h8000_1005);
    @(negedge clk);
    check(n_starts, 1, "R3 one start pulse");
    check({28'b0, eng_protocol}, 8, "R3 protocol");
    check({24'b0, eng_rd_count}, 5, "R3 count");
    br(8'h30, 32'h8000_1005, "R3 busy readback");
    bw(8'h30, 32'h8000_0E01);
    @(negedge clk);
    check(n_starts, 1, "R3 no restart while busy");
    check({28'b0, eng_protocol}, 8, "R3 protocol held");
    // R4/R5 completion, R8 receive
    rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
    check({31'b0, irq}, 0, "R5 irq before done");
    done(3'd3);
    br(8'h30, 32'h0600_1005, "R4 status captured");
    br(8'h3C, 32'h1000_0000, "R5 flag set");
    check({31'b0, irq}, 1, "R5 irq");
    br(8'h0C, 32'h0003_0000, "R8 level 3");
    br(8'h44, 32'h11, "R8 pop1"); br(8'h44, 32'h22, "R8 pop2");
    br(8'h44, 32'h33, "R8 pop3"); br(8'h44, 0, "R8 empty read");
    br(8'h0C, 0, "R8 level after empty read");
    // R6 write-1-to-clear
    bw(8'h3C, 32'h0);
    br(8'h3C, 32'h1000_0000, "R6 write zero keeps flag");
    bw(8'h3C, 32'h1000_0000);
    br(8'h3C, 0, "R6 cleared");
    check({31'b0, irq}, 0, "R6 irq low");
    // R5 masked
    bw(8'h38, 0);
    bw(8'h30, 32'h8000_0E00);
    br(8'h30, 32'h8000_0E00, "R4 status cleared on start");
    done(3'd0);
    br(8'h3C, 32'h1000_0000, "R5 masked flag set");
    check({31'b0, irq}, 0, "R5 masked irq");
    bw(8'h3C, 32'h1000_0000);
    // R8 receive full, R9 flush
    for (int i = 0; i < 66; i++) rx_push(i[7:0]);
    br(8'h0C, 32'h0040_0000, "R8 level full");
    br(8'h44, 32'h0, "R8 first of full");
    bw(8'h0C, 32'h8000_0000);
    br(8'h0C, 0, "R9 rx flushed");
    br(8'h44, 0, "R9 rx empty read");
    // R7 transmit full
    for (int i = 0; i < 65; i++) bw(8'h40, {24'b0, i[7:0]});
    for (int i = 0; i < 64; i++) tx_pop(i[7:0], 0, "R7 full order");
    @(negedge clk); check({31'b0, eng_tx_valid}, 0, "R7 overflow dropped");
    bw(8'h40, 32'h55);
    bw(8'h0C, 32'h4000_0000);
    @(negedge clk); check({31'b0, eng_tx_valid}, 0, "R9 tx flushed");
    // R10 soft reset
    bw(8'h30, 32'h8000_0201);
    bw(8'h40, 32'h66); rx_push(8'h77);
    bw(8'h00, 32'hC000_0000);
    bw(8'h40, 32'h88);
    br(8'h30, 0, "R10 cmd cleared");
    br(8'h0C, 0, "R10 rx cleared");
    br(8'h3C, 0, "R10 flag clear");
    check({31'b0, eng_tx_valid}, 0, "R10 tx cleared and write dropped");
    bw(8'h00, 32'h4000_0000);
    br(8'h00, 32'h4000_0000, "R10 released");
    repeat (3) @(negedge clk);
    check(exp_q.size(), 0, "scoreboard drained");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule